// File: doc/BRIEF.md
# Multi-Mode 8x8 Multiplier

This unit multiplies two 8-bit operands in one of six arithmetic modes. Both operands can be unsigned, both can be two's complement, or the first can be two's complement while the second is unsigned. Each of these three forms also has a fractional variant. That variant treats the operands as 1.7 fixed-point values, so the 16-bit product is shifted left by one bit. The 16-bit result is split into a high byte and a low byte. The surrounding datapath writes the high byte to register 1 and the low byte to register 0 of its register file. The unit also produces a zero flag and a carry flag.

A client pulses `start` for one cycle with the operands and the mode. The unit samples the inputs in that cycle. Two cycles later it raises `done` for one cycle, and `done` serves as the write strobe for the result pair and the two flags. The unit is a two-stage pipeline, so a new start may be issued in every cycle, and each start produces its own `done` pulse. Fetching the operands and writing the register file are left to the surrounding datapath.

Top module: `mulx_top`

## Requirements
- R1: Mode 3'b000 returns the unsigned product of `op_a` and `op_b`.
- R2: Mode 3'b001 treats both operands as two's complement and returns the 16-bit two's-complement product.
- R3: Mode 3'b010 treats `op_a` as two's complement and `op_b` as unsigned, and returns the 16-bit two's-complement product.
- R4: When `mode[2]` is 1 (modes 3'b100, 3'b101 and 3'b110), the result is the product of the form selected by `mode[1:0]`, shifted left by one bit and truncated to 16 bits.
- R5: `flag_c` equals bit 15 of the 16-bit product before any fractional shift.
- R6: `flag_z` is 1 exactly when the final 16-bit result is zero.
- R7: `done` is high for one cycle, in the second cycle after a cycle in which `start` is high. Back-to-back starts each produce their own `done` pulse. `done` is never high otherwise.
- R8: `mode[1:0]` = 2'b11 is handled as unsigned-by-unsigned, with `mode[2]` still selecting the fractional shift.
- R9: Reset drives all outputs to 0. Between `done` pulses the product and flag outputs keep their last values.
- R10: `res_hi` carries bits 15:8 of the result (for register 1) and `res_lo` carries bits 7:0 (for register 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication; the inputs are sampled in this cycle |
| mode | input | 3 | Bit 2 selects fractional; bits 1:0 select 00 unsigned, 01 signed, 10 signed by unsigned, 11 unsigned |
| op_a | input | 8 | First operand |
| op_b | input | 8 | Second operand |
| done | output | 1 | Result valid and write strobe |
| res_hi | output | 8 | Result bits 15:8 |
| res_lo | output | 8 | Result bits 7:0 |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The latency assertions assume that `start` is low while `rst` is high, so that no request is in flight when the reset ends. The driver keeps `start` low throughout the reset. The assertion that zero excludes carry relies on a fact about 8-bit operands: no mode can produce an unshifted product whose low 15 bits are zero while bit 15 is set. The stimulus covers each mode's extreme operands, including the most negative values, all-ones operands and zero, so this property is exercised at its edges.

// File: rtl/mulx_pkg.sv
package mulx_pkg;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    KIND_UU  = 2'b00,
    KIND_SS  = 2'b01,
    KIND_SU  = 2'b10,
    KIND_RSV = 2'b11
  } kind_e;

  // operand index 0 is op_a, 1 is op_b
  function automatic logic opnd_signed(input logic [1:0] kind, input int idx);
    if (idx == 0) return (kind == KIND_SS) || (kind == KIND_SU);
    else          return (kind == KIND_SS);
  endfunction
endpackage

// File: rtl/mulx_extend.sv
module mulx_extend #(
  parameter int W = 8
) (
  input  logic [W-1:0]    din,
  input  logic            is_signed,
  output logic signed [W:0] dout
);
  always_comb dout = {is_signed & din[W-1], din};
endmodule

// File: rtl/mulx_stage1.sv
module mulx_stage1 #(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [mulx_pkg::MODE_W-1:0] mode,
  input  logic [W-1:0]               op_a,
  input  logic [W-1:0]               op_b,
  output logic                       vld_q,
  output logic                       frac_q,
  output logic [2*W-1:0]             raw_q
);
  import mulx_pkg::*;
  localparam int PW = 2 * W + 2;

  logic [W-1:0]      opnd [2];
  logic signed [W:0] ext  [2];
  logic signed [PW-1:0] prod;

  assign opnd[0] = op_a;
  assign opnd[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_ext
    mulx_extend #(.W(W)) u_ext (
      .din      (opnd[i]),
      .is_signed(opnd_signed(mode[1:0], i)),
      .dout     (ext[i])
    );
  end

  always_comb prod = PW'(ext[0]) * PW'(ext[1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      frac_q <= 1'b0;
      raw_q  <= '0;
    end else begin
      vld_q <= start;
      if (start) begin
        frac_q <= mode[2];
        raw_q  <= prod[2*W-1:0];
      end
    end
  end
endmodule

// File: rtl/mulx_stage2.sv
module mulx_stage2 #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vld_i,
  input  logic           frac_i,
  input  logic [2*W-1:0] raw_i,
  output logic           done,
  output logic [W-1:0]   res_hi,
  output logic [W-1:0]   res_lo,
  output logic           flag_z,
  output logic           flag_c
);
  logic [2*W-1:0] fin;

  always_comb fin = frac_i ? {raw_i[2*W-2:0], 1'b0} : raw_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      done   <= 1'b0;
      res_hi <= '0;
      res_lo <= '0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
    end else begin
      done <= vld_i;
      if (vld_i) begin
        res_hi <= fin[2*W-1:W];
        res_lo <= fin[W-1:0];
        flag_z <= (fin == '0);
        flag_c <= raw_i[2*W-1];
      end
    end
  end

  // R4: fractional results always have a clear LSB
  p_frac_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (done && $past(frac_i)) |-> (res_lo[0] == 1'b0));

  // R5: without the shift, carry mirrors the result MSB
  p_carry_msb_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(frac_i)) |-> (flag_c == res_hi[W-1]));

  // R6: a zero result can never carry for byte operands
  p_zero_no_carry_r6: assert property (@(posedge clk) disable iff (rst)
    (done && flag_z) |-> !flag_c);

  // R9: outputs hold between strobes
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(res_hi) && $stable(res_lo) && $stable(flag_z) && $stable(flag_c)));
endmodule

// File: rtl/mulx_top.sv
module mulx_top #(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [mulx_pkg::MODE_W-1:0] mode,
  input  logic [W-1:0]               op_a,
  input  logic [W-1:0]               op_b,
  output logic                       done,
  output logic [W-1:0]               res_hi,
  output logic [W-1:0]               res_lo,
  output logic                       flag_z,
  output logic                       flag_c
);
  logic           s1_vld;
  logic           s1_frac;
  logic [2*W-1:0] s1_raw;

  mulx_stage1 #(.W(W)) u_s1 (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .mode  (mode),
    .op_a  (op_a),
    .op_b  (op_b),
    .vld_q (s1_vld),
    .frac_q(s1_frac),
    .raw_q (s1_raw)
  );

  mulx_stage2 #(.W(W)) u_s2 (
    .clk   (clk),
    .rst   (rst),
    .vld_i (s1_vld),
    .frac_i(s1_frac),
    .raw_i (s1_raw),
    .done  (done),
    .res_hi(res_hi),
    .res_lo(res_lo),
    .flag_z(flag_z),
    .flag_c(flag_c)
  );

  // R7: every start yields a strobe two cycles later, and only then
  p_start_done_r7: assert property (@(posedge clk) disable iff (rst)
    $past(start, 2) |-> done);
  p_done_cause_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(start, 2));
endmodule

// File: tb/mulx_top_tb.sv
module mulx_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       start;
  logic [2:0] mode;
  logic [7:0] op_a, op_b;
  logic       done, flag_z, flag_c;
  logic [7:0] res_hi, res_lo;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [15:0] res;
    logic        z;
    logic        c;
    int          due;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mulx_top u_dut (
    .clk(clk), .rst(rst), .start(start), .mode(mode),
    .op_a(op_a), .op_b(op_b), .done(done),
    .res_hi(res_hi), .res_lo(res_lo), .flag_z(flag_z), .flag_c(flag_c)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b, input string tag);
    exp_t e;
    int av, bv, p;
    logic [15:0] raw;
    av = (m[1:0] == 2'b01 || m[1:0] == 2'b10) ? int'($signed(a)) : int'(a);
    bv = (m[1:0] == 2'b01) ? int'($signed(b)) : int'(b);
    p = av * bv;
    raw = p[15:0];
    e.res = m[2] ? {raw[14:0], 1'b0} : raw;
    e.c = raw[15];
    e.z = (e.res == 16'h0);
    e.tag = tag;
    e.due = 0;
    return e;
  endfunction

  // driver: called at a negedge, holds start for one cycle
  task automatic issue(input logic [2:0] m, input logic [7:0] a, input logic [7:0] b, input string tag);
    exp_t e;
    e = model(m, a, b, tag);
    e.due = cyc + 2;
    sb.push_back(e);
    start = 1'b1; mode = m; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R7 spurious done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          last = e;
          chk(e.due == cyc, {e.tag, " R7 latency"}, cyc, e.due);
          chk({res_hi, res_lo} == e.res, {e.tag, " R10 result"}, {res_hi, res_lo}, e.res);
          chk(flag_c == e.c, {e.tag, " R5 carry"}, flag_c, e.c);
          chk(flag_z == e.z, {e.tag, " R6 zero"}, flag_z, e.z);
        end
      end else if (sb.size() != 0 && sb[0].due <= cyc) begin
        chk(1'b0, {sb[0].tag, " R7 missing done"}, cyc, sb[0].due);
        void'(sb.pop_front());
      end
    end
  end

  initial begin
    rst = 1'b1; start = 1'b0; mode = 3'b000; op_a = 8'h00; op_b = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk({done, res_hi, res_lo, flag_z, flag_c} == 19'h0, "R9 reset state",
        {done, res_hi, res_lo, flag_z, flag_c}, 0);

    issue(3'b000, 8'hFF, 8'hFF, "R1 uu max");
    issue(3'b000, 8'h12, 8'h34, "R1 uu mid");
    issue(3'b000, 8'h00, 8'h9C, "R6 uu zero");
    issue(3'b001, 8'h80, 8'h80, "R2 ss negneg");
    issue(3'b001, 8'h80, 8'h7F, "R2 ss negpos");
    issue(3'b001, 8'hFF, 8'h01, "R2 ss minus1");
    issue(3'b010, 8'h80, 8'hFF, "R3 su negmax");
    issue(3'b010, 8'h7F, 8'hFF, "R3 su posmax");
    issue(3'b010, 8'hFE, 8'h03, "R3 su small");
    issue(3'b100, 8'h80, 8'h80, "R4 frac uu");
    issue(3'b101, 8'h80, 8'h80, "R4 frac ss");
    issue(3'b101, 8'h40, 8'hC0, "R4 frac ss neg");
    issue(3'b110, 8'h80, 8'hFF, "R4 frac su");
    issue(3'b100, 8'h00, 8'h55, "R6 frac zero");
    issue(3'b011, 8'hFF, 8'hFF, "R8 rsv uu");
    issue(3'b111, 8'h81, 8'h02, "R8 rsv frac");
    repeat (4) @(negedge clk);

    // spaced requests and hold behaviour
    issue(3'b001, 8'hF0, 8'h10, "R7 spaced");
    repeat (6) @(negedge clk);
    chk({res_hi, res_lo} == last.res, "R9 hold result", {res_hi, res_lo}, last.res);
    chk(flag_c == last.c && flag_z == last.z, "R9 hold flags", {flag_z, flag_c}, {last.z, last.c});
    chk(done == 1'b0, "R7 idle done", done, 0);

    // inputs changing without start have no effect
    mode = 3'b000; op_a = 8'h11; op_b = 8'h22;
    repeat (3) @(negedge clk);
    chk({res_hi, res_lo} == last.res, "R9 no start no change", {res_hi, res_lo}, last.res);
    chk(sb.size() == 0, "R7 all drained", sb.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5 * 5000);
    errors++;
    $display("FAIL watchdog R7: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule